// File: doc/BRIEF.md
# Banked Channel Monitor Register File

This block is the register side of a sensor monitor that watches a small set of channels, such as temperatures or supply voltages. It keeps, for each channel, a configuration byte with an enable bit, the most recent reading, and three thresholds: upper, lower and critical. Software reaches all of one channel's state through a single window of offsets. A channel-select register at offset 0x09 chooses which channel that window shows.

Readings arrive on a sample stream that carries a channel index and a data byte. The block takes a reading only when the addressed channel is enabled. It then compares the reading with that channel's upper and lower thresholds. A reading outside the window latches the channel's event flag. Software clears the flags by writing ones. Two mask registers decide which latched flags drive the interrupt line and which drive the system-management line. The comparison is signed or unsigned, chosen by a parameter: signed suits temperatures in degrees, unsigned suits voltage codes.

The sample stream has a valid/ready handshake, but the block never applies back-pressure. Ready stays high, and a sample is consumed in every cycle that valid is high.

Top module: `bankmon`

## Requirements
- R1: After reset, irq_o and smi_o are 0, and the event, mask, rate, global-config, select, channel-config and reading registers all read 0. The upper and critical thresholds read 0x7F (signed mode) or 0xFF (unsigned mode), and the lower threshold reads 0x80 (signed mode) or 0x00 (unsigned mode).
- R2: Writing offset 0x09 stores the low 4 bits of the write data as the selected channel. Offsets 0x0A (config, bit 0 = enable), 0x0C (upper), 0x0D (lower) and 0x0E (critical) read and write only the selected channel's copy.
- R3: When the selected channel is NUM_CH or above, writes to 0x0A, 0x0C, 0x0D and 0x0E change no channel, and reads of 0x0A to 0x0E return 0.
- R4: Offset 0x0B returns the selected channel's latest accepted reading, and writes to 0x0B are ignored.
- R5: smp_ready is always 1. A sample for a channel whose enable bit is 0 leaves that channel's reading unchanged and raises no event.
- R6: An accepted sample sets the channel's event flag when the sample is strictly above the upper threshold or strictly below the lower threshold. A sample equal to either threshold sets nothing. The thresholds used are the values held before the sample's clock edge.
- R7: With SIGNED_CMP=1 (the default), samples and thresholds are compared as two's-complement bytes. For example, 0x90 lies within the default window 0x80..0x7F.
- R8: The event flags for channels 0-7 are at offset 0x00 (bit n = channel n), and those for channels 8-15 are at 0x01. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged. If a clear and a new event hit the same flag in one cycle, the flag ends set.
- R9: irq_o is the OR of the event flags ANDed with the interrupt mask at 0x04/0x05. smi_o is the same OR using the system-management mask at 0x02/0x03. Both follow the flags and masks in the cycle after the edge that changes them.
- R10: reg_rdata is loaded at the clock edge where reg_rd is high and holds its value otherwise. Offsets 0x06 and 0x0F read 0 and ignore writes.
- R11: Offsets 0x07 (conversion rate) and 0x08 (global configuration) are 8-bit read/write storage.
- R12: A sample whose channel index is NUM_CH or above changes no reading and no event flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready, constant 1 |
| smp_chan | input | 4 | Channel index of the sample |
| smp_data | input | 8 | Sample value |
| irq_o | output | 1 | Interrupt request |
| smi_o | output | 1 | System-management request |

## Verification
Every result of this block appears one clock after its stimulus. A register write or an accepted sample changes the state at the next rising edge, irq_o and smi_o follow that state at once, and reg_rdata is loaded at the edge where reg_rd is high. The bench drives inputs at falling edges. At each rising edge it advances a behavioural model of the registers using the same pre-edge inputs, so the thresholds a sample sees match the ones the design uses. It compares irq_o, smi_o and reg_rdata at the next falling edge. Directed reads add hand-computed expectations for thresholds at their boundaries, signed comparison, a clear and an event in the same cycle, out-of-range selects and out-of-range sample indices.

// File: rtl/bankmon_pkg.sv
package bankmon_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;
  localparam int SEL_W  = 4;
  localparam int MAX_CH = 2 ** SEL_W;

  localparam logic [ADDR_W-1:0] OFF_EVT_LO  = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_EVT_HI  = 4'h1;
  localparam logic [ADDR_W-1:0] OFF_SMI_LO  = 4'h2;
  localparam logic [ADDR_W-1:0] OFF_SMI_HI  = 4'h3;
  localparam logic [ADDR_W-1:0] OFF_IRQ_LO  = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_IRQ_HI  = 4'h5;
  localparam logic [ADDR_W-1:0] OFF_RATE    = 4'h7;
  localparam logic [ADDR_W-1:0] OFF_GCFG    = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_SEL     = 4'h9;
  localparam logic [ADDR_W-1:0] OFF_CCFG    = 4'hA;
  localparam logic [ADDR_W-1:0] OFF_VAL     = 4'hB;
  localparam logic [ADDR_W-1:0] OFF_UPPER   = 4'hC;
  localparam logic [ADDR_W-1:0] OFF_LOWER   = 4'hD;
  localparam logic [ADDR_W-1:0] OFF_CRIT    = 4'hE;

  // Outside-window test; signed mode treats every byte as two's complement.
  function automatic logic outside(input logic [BYTE_W-1:0] d,
                                   input logic [BYTE_W-1:0] up,
                                   input logic [BYTE_W-1:0] lo,
                                   input bit sgn);
    if (sgn) return ($signed(d) > $signed(up)) || ($signed(d) < $signed(lo));
    else     return (d > up) || (d < lo);
  endfunction
endpackage

// File: rtl/bankmon_chan.sv
module bankmon_chan
  import bankmon_pkg::*;
#(
  parameter bit SIGNED_CMP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cfg,
  input  logic              wr_up,
  input  logic              wr_lo,
  input  logic              wr_crit,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              smp_hit,
  input  logic [BYTE_W-1:0] smp_data,
  output logic [BYTE_W-1:0] cfg_q,
  output logic [BYTE_W-1:0] val_q,
  output logic [BYTE_W-1:0] up_q,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] crit_q,
  output logic              evt
);
  localparam logic [BYTE_W-1:0] UP_RST = SIGNED_CMP ? 8'h7F : 8'hFF;
  localparam logic [BYTE_W-1:0] LO_RST = SIGNED_CMP ? 8'h80 : 8'h00;

  logic take;
  assign take = smp_hit && cfg_q[0];
  assign evt  = take && outside(smp_data, up_q, lo_q, SIGNED_CMP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      val_q  <= '0;
      up_q   <= UP_RST;
      lo_q   <= LO_RST;
      crit_q <= UP_RST;
    end else begin
      if (wr_cfg)  cfg_q  <= wdata;
      if (wr_up)   up_q   <= wdata;
      if (wr_lo)   lo_q   <= wdata;
      if (wr_crit) crit_q <= wdata;
      if (take)    val_q  <= smp_data;
    end
  end
endmodule

// File: rtl/bankmon_event.sv
module bankmon_event
  import bankmon_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic [NUM_CH-1:0] set_vec,
  output logic [MAX_CH-1:0] status_q,
  output logic [MAX_CH-1:0] smi_mask_q,
  output logic [MAX_CH-1:0] irq_mask_q,
  output logic              irq_o,
  output logic              smi_o
);
  logic [MAX_CH-1:0] clr_vec;
  logic [MAX_CH-1:0] set_wide;

  always_comb begin
    clr_vec = '0;
    if (reg_wr && reg_addr == OFF_EVT_LO) clr_vec[7:0]  = reg_wdata;
    if (reg_wr && reg_addr == OFF_EVT_HI) clr_vec[15:8] = reg_wdata;
  end

  generate
    if (NUM_CH < MAX_CH) begin : g_pad
      assign set_wide = {{(MAX_CH-NUM_CH){1'b0}}, set_vec};
    end else begin : g_full
      assign set_wide = set_vec;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q   <= '0;
      smi_mask_q <= '0;
      irq_mask_q <= '0;
    end else begin
      status_q <= (status_q & ~clr_vec) | set_wide;
      if (reg_wr) begin
        case (reg_addr)
          OFF_SMI_LO: smi_mask_q[7:0]  <= reg_wdata;
          OFF_SMI_HI: smi_mask_q[15:8] <= reg_wdata;
          OFF_IRQ_LO: irq_mask_q[7:0]  <= reg_wdata;
          OFF_IRQ_HI: irq_mask_q[15:8] <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  assign irq_o = |(status_q & irq_mask_q);
  assign smi_o = |(status_q & smi_mask_q);
endmodule

// File: rtl/bankmon.sv
module bankmon
  import bankmon_pkg::*;
#(
  parameter int NUM_CH     = 3,
  parameter bit SIGNED_CMP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [3:0]        smp_chan,
  input  logic [7:0]        smp_data,
  output logic              irq_o,
  output logic              smi_o
);
  logic [SEL_W-1:0]  sel_q;
  logic [BYTE_W-1:0] rate_q;
  logic [BYTE_W-1:0] gcfg_q;
  logic [NUM_CH-1:0] evt_vec;
  logic [NUM_CH-1:0] chan_en;
  logic [MAX_CH-1:0] evt_status;
  logic [MAX_CH-1:0] smi_mask;
  logic [MAX_CH-1:0] irq_mask;
  logic [BYTE_W-1:0] c_cfg  [NUM_CH];
  logic [BYTE_W-1:0] c_val  [NUM_CH];
  logic [BYTE_W-1:0] c_up   [NUM_CH];
  logic [BYTE_W-1:0] c_lo   [NUM_CH];
  logic [BYTE_W-1:0] c_crit [NUM_CH];
  logic [BYTE_W-1:0] rd_next;

  assign smp_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      rate_q <= '0;
      gcfg_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFF_SEL:  sel_q  <= reg_wdata[SEL_W-1:0];
        OFF_RATE: rate_q <= reg_wdata;
        OFF_GCFG: gcfg_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic mine;
      assign mine = reg_wr && (sel_q == SEL_W'(i));
      bankmon_chan #(.SIGNED_CMP(SIGNED_CMP)) i_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cfg   (mine && reg_addr == OFF_CCFG),
        .wr_up    (mine && reg_addr == OFF_UPPER),
        .wr_lo    (mine && reg_addr == OFF_LOWER),
        .wr_crit  (mine && reg_addr == OFF_CRIT),
        .wdata    (reg_wdata),
        .smp_hit  (smp_valid && smp_chan == SEL_W'(i)),
        .smp_data (smp_data),
        .cfg_q    (c_cfg[i]),
        .val_q    (c_val[i]),
        .up_q     (c_up[i]),
        .lo_q     (c_lo[i]),
        .crit_q   (c_crit[i]),
        .evt      (evt_vec[i])
      );
      assign chan_en[i] = c_cfg[i][0];
    end
  endgenerate

  bankmon_event #(.NUM_CH(NUM_CH)) i_event (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .set_vec    (evt_vec),
    .status_q   (evt_status),
    .smi_mask_q (smi_mask),
    .irq_mask_q (irq_mask),
    .irq_o      (irq_o),
    .smi_o      (smi_o)
  );

  always_comb begin
    rd_next = '0;
    case (reg_addr)
      OFF_EVT_LO: rd_next = evt_status[7:0];
      OFF_EVT_HI: rd_next = evt_status[15:8];
      OFF_SMI_LO: rd_next = smi_mask[7:0];
      OFF_SMI_HI: rd_next = smi_mask[15:8];
      OFF_IRQ_LO: rd_next = irq_mask[7:0];
      OFF_IRQ_HI: rd_next = irq_mask[15:8];
      OFF_RATE:   rd_next = rate_q;
      OFF_GCFG:   rd_next = gcfg_q;
      OFF_SEL:    rd_next = {{(BYTE_W-SEL_W){1'b0}}, sel_q};
      default: begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (sel_q == SEL_W'(i)) begin
            case (reg_addr)
              OFF_CCFG:  rd_next = c_cfg[i];
              OFF_VAL:   rd_next = c_val[i];
              OFF_UPPER: rd_next = c_up[i];
              OFF_LOWER: rd_next = c_lo[i];
              OFF_CRIT:  rd_next = c_crit[i];
              default: ;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_next;
  end
endmodule

// File: rtl/bankmon_chk.sv
module bankmon_chk
  import bankmon_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [3:0]        reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic              smp_valid,
  input logic [3:0]        smp_chan,
  input logic              irq_o,
  input logic              smi_o,
  input logic [MAX_CH-1:0] status,
  input logic [NUM_CH-1:0] en_vec
);
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata)); // R10

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(smp_valid) ||
      $past(reg_wr && (reg_addr == OFF_IRQ_LO || reg_addr == OFF_IRQ_HI))); // R9

  AST_SMI_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_o) |-> $past(smp_valid) ||
      $past(reg_wr && (reg_addr == OFF_SMI_LO || reg_addr == OFF_SMI_HI))); // R9

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ck
      AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_chan == 4'(i) && !en_vec[i] && !status[i]) |=> !status[i]); // R5

      if (i < 8) begin : g_lo
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
          (reg_wr && reg_addr == OFF_EVT_LO && reg_wdata[i] &&
           !(smp_valid && smp_chan == 4'(i))) |=> !status[i]); // R8
      end
    end
  endgenerate
endmodule

bind bankmon bankmon_chk #(.NUM_CH(NUM_CH)) i_bankmon_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .smp_valid (smp_valid),
  .smp_chan  (smp_chan),
  .irq_o     (irq_o),
  .smi_o     (smi_o),
  .status    (evt_status),
  .en_vec    (chan_en)
);

// File: tb/test_bankmon.sv
module test_bankmon;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic smp_valid = 1'b0;
  logic smp_ready;
  logic [3:0] smp_chan = '0;
  logic [7:0] smp_data = '0;
  logic irq_o, smi_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  bankmon i_bankmon (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_chan(smp_chan),
    .smp_data(smp_data), .irq_o(irq_o), .smi_o(smi_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic [7:0] m_cfg[16], m_val[16], m_up[16], m_lo[16], m_crit[16];
  logic [15:0] m_stat, m_smi, m_irq;
  logic [7:0] m_rate, m_gcfg, m_rd;
  logic [3:0] m_sel;

  function automatic int sv(input logic [7:0] x);
    return (x >= 8'h80) ? int'(x) - 256 : int'(x);
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a);
    bit ok = (int'(m_sel) < NCH);
    case (a)
      4'h0: return m_stat[7:0];
      4'h1: return m_stat[15:8];
      4'h2: return m_smi[7:0];
      4'h3: return m_smi[15:8];
      4'h4: return m_irq[7:0];
      4'h5: return m_irq[15:8];
      4'h7: return m_rate;
      4'h8: return m_gcfg;
      4'h9: return {4'h0, m_sel};
      4'hA: return ok ? m_cfg[m_sel] : 8'h00;
      4'hB: return ok ? m_val[m_sel] : 8'h00;
      4'hC: return ok ? m_up[m_sel] : 8'h00;
      4'hD: return ok ? m_lo[m_sel] : 8'h00;
      4'hE: return ok ? m_crit[m_sel] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin
        m_cfg[i] = 0; m_val[i] = 0; m_up[i] = 8'h7F; m_lo[i] = 8'h80; m_crit[i] = 8'h7F;
      end
      m_stat = 0; m_smi = 0; m_irq = 0; m_rate = 0; m_gcfg = 0; m_rd = 0; m_sel = 0;
    end else begin
      logic [15:0] setv, clrv;
      int ch;
      setv = 0; clrv = 0;
      if (reg_rd) m_rd = m_read(reg_addr);
      ch = int'(smp_chan);
      if (smp_valid && ch < NCH && m_cfg[ch][0]) begin
        if (sv(smp_data) > sv(m_up[ch]) || sv(smp_data) < sv(m_lo[ch])) setv[ch] = 1'b1;
        m_val[ch] = smp_data;
      end
      if (reg_wr) begin
        case (reg_addr)
          4'h0: clrv[7:0] = reg_wdata;
          4'h1: clrv[15:8] = reg_wdata;
          4'h2: m_smi[7:0] = reg_wdata;
          4'h3: m_smi[15:8] = reg_wdata;
          4'h4: m_irq[7:0] = reg_wdata;
          4'h5: m_irq[15:8] = reg_wdata;
          4'h7: m_rate = reg_wdata;
          4'h8: m_gcfg = reg_wdata;
          4'h9: m_sel = reg_wdata[3:0];
          4'hA: if (int'(m_sel) < NCH) m_cfg[m_sel] = reg_wdata;
          4'hC: if (int'(m_sel) < NCH) m_up[m_sel] = reg_wdata;
          4'hD: if (int'(m_sel) < NCH) m_lo[m_sel] = reg_wdata;
          4'hE: if (int'(m_sel) < NCH) m_crit[m_sel] = reg_wdata;
          default: ;
        endcase
      end
      m_stat = (m_stat & ~clrv) | setv;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Model comparison on every falling edge after reset
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R9 irq_o vs model", int'(irq_o), int'(|(m_stat & m_irq)));
      check("R9 smi_o vs model", int'(smi_o), int'(|(m_stat & m_smi)));
      check("R10 reg_rdata vs model", int'(reg_rdata), int'(m_rd));
      check("R5 smp_ready", int'(smp_ready), 1);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdx(input logic [3:0] a, input logic [7:0] exp, input string tag);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check(tag, int'(reg_rdata), int'(exp));
  endtask

  task automatic smp(input logic [3:0] c, input logic [7:0] d);
    smp_valid = 1'b1; smp_chan = c; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  initial begin
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    check("R1 irq_o after reset", int'(irq_o), 0);
    check("R1 smi_o after reset", int'(smi_o), 0);
    rdx(4'hC, 8'h7F, "R1 upper reset");
    rdx(4'hD, 8'h80, "R1 lower reset");
    rdx(4'hE, 8'h7F, "R1 critical reset");
    rdx(4'hA, 8'h00, "R1 config reset");
    rdx(4'h9, 8'h00, "R1 select reset");
    rdx(4'h0, 8'h00, "R1 status reset");
    // R2 banked access
    wr(4'h9, 8'hF1);
    rdx(4'h9, 8'h01, "R2 select keeps low 4 bits");
    wr(4'hA, 8'h01); wr(4'hC, 8'h40); wr(4'hD, 8'h10); wr(4'hE, 8'h60);
    rdx(4'hC, 8'h40, "R2 ch1 upper");
    rdx(4'hE, 8'h60, "R2 ch1 critical");
    wr(4'h9, 8'h00);
    rdx(4'hC, 8'h7F, "R2 ch0 upper untouched");
    rdx(4'hA, 8'h00, "R2 ch0 config untouched");
    // R5 disabled channel
    smp(4'h0, 8'h55);
    rdx(4'hB, 8'h00, "R5 disabled reading held");
    rdx(4'h0, 8'h00, "R5 disabled no event");
    wr(4'hA, 8'h01);
    smp(4'h0, 8'h22);
    rdx(4'hB, 8'h22, "R4 reading after enable");
    wr(4'hB, 8'h99);
    rdx(4'hB, 8'h22, "R4 reading is read-only");
    // R7 signed compare: 0x90 = -112 inside 0x80..0x7F
    smp(4'h0, 8'h90);
    rdx(4'h0, 8'h00, "R7 signed in-window");
    rdx(4'hB, 8'h90, "R7 reading stored");
    // R6 boundaries on ch1 (0x10..0x40)
    smp(4'h1, 8'h40);
    smp(4'h1, 8'h10);
    rdx(4'h0, 8'h00, "R6 equal to limits no event");
    smp(4'h1, 8'h41);
    rdx(4'h0, 8'h02, "R6 above upper");
    // R9 masks
    check("R9 irq unmasked low", int'(irq_o), 0);
    wr(4'h4, 8'h02);
    check("R9 irq after mask", int'(irq_o), 1);
    check("R9 smi still low", int'(smi_o), 0);
    wr(4'h2, 8'h02);
    check("R9 smi after mask", int'(smi_o), 1);
    // R8 write-1-to-clear
    wr(4'h0, 8'h01);
    rdx(4'h0, 8'h02, "R8 zero bit keeps flag");
    wr(4'h0, 8'h02);
    check("R8 irq after clear", int'(irq_o), 0);
    rdx(4'h0, 8'h00, "R8 cleared");
    smp(4'h1, 8'h90);
    rdx(4'h0, 8'h02, "R7 0x90 below lower 0x10 signed");
    reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 8'h02;
    smp_valid = 1'b1; smp_chan = 4'h1; smp_data = 8'h05;
    @(negedge clk);
    reg_wr = 1'b0; smp_valid = 1'b0;
    rdx(4'h0, 8'h02, "R8 set wins over clear");
    rdx(4'h1, 8'h00, "R8 upper status byte");
    wr(4'h0, 8'hFF);
    // R6 old limits used on same-cycle write
    wr(4'h9, 8'h01);
    reg_wr = 1'b1; reg_addr = 4'hC; reg_wdata = 8'h70;
    smp_valid = 1'b1; smp_chan = 4'h1; smp_data = 8'h50;
    @(negedge clk);
    reg_wr = 1'b0; smp_valid = 1'b0;
    rdx(4'h0, 8'h02, "R6 compare uses pre-edge upper");
    wr(4'h0, 8'h02);
    // R5 disable ch1 and sample out of window
    wr(4'hA, 8'h00);
    smp(4'h1, 8'h7F);
    rdx(4'h0, 8'h00, "R5 disabled ch1 no event");
    rdx(4'hB, 8'h50, "R5 disabled ch1 value held");
    // R12 out-of-range sample index
    wr(4'hA, 8'h01);
    smp(4'h3, 8'h7F);
    smp(4'hF, 8'h7F);
    rdx(4'h0, 8'h00, "R12 bad index no event");
    rdx(4'hB, 8'h50, "R12 bad index no value change");
    // R3 out-of-range select
    wr(4'h9, 8'h05);
    wr(4'hC, 8'h11); wr(4'hA, 8'h01);
    rdx(4'hC, 8'h00, "R3 out-of-range upper reads 0");
    rdx(4'hB, 8'h00, "R3 out-of-range reading reads 0");
    rdx(4'h9, 8'h05, "R3 select readback");
    wr(4'h9, 8'h02);
    rdx(4'hC, 8'h7F, "R3 ch2 upper untouched");
    rdx(4'hA, 8'h00, "R3 ch2 config untouched");
    // R10 unmapped offsets, R11 storage
    wr(4'h6, 8'hAA);
    rdx(4'h6, 8'h00, "R10 offset 6 reads 0");
    rdx(4'hF, 8'h00, "R10 offset F reads 0");
    wr(4'h7, 8'h5A);
    rdx(4'h7, 8'h5A, "R11 rate storage");
    wr(4'h8, 8'hC3);
    rdx(4'h8, 8'hC3, "R11 global config storage");
    repeat (3) @(negedge clk);
    check("R10 rdata held without read", int'(reg_rdata), 8'hC3);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule